// File: doc/BRIEF.md
# Preset-Terminated Multichannel Counter Bank

This block holds a bank of event counters, one for each input channel, split into equal groups. While the bank is running, each channel adds one for every clock cycle in which its pulse input is high. A per-channel inhibit mask removes single channels from counting. The preset logic does not look at it.

Each group has a select field that names one of its own channels as the preset channel, and a target value. An enable bit for each group decides whether that group can end the run. The first enabled preset channel whose count is equal to or greater than its group's target stops counting on every channel. A fixed pipeline of a few cycles sits between the compare and the stop, so the stored counts can pass the target by that many pulses. A sticky hit flag for each group records which group ended the run.

A host starts, stops and clears the bank, programs the targets and the setup, and reads any counter at any time through a flat register port. Reads are combinational and have no effect on counting.

Top module: `presetctr_bank`

## Requirements
- R1: After reset, every counter reads 0. The control register (address 0x20) reads 0, meaning stopped with no hit flag. Both target registers (0x21, 0x22) and the setup register (0x23) read 0.
- R2: While running, channel i (0 to 31, read at address i) adds exactly one on each clock edge at which pulse_in[i] is high and inhibit_mask[i] is low.
- R3: A channel whose inhibit_mask bit is high keeps its value whatever its pulse input does.
- R4: Writing the control register with bit 0 set starts the bank, and with bit 1 set stops it. Control read bit 0 shows the running state. While stopped, no counter changes except through a clear.
- R5: Writing the control register with bit 2 set clears every counter to 0 on that clock edge.
- R6: Reading a counter while the bank runs returns its current value and loses no pulse. During an unbroken pulse train, two reads taken k cycles apart differ by k.
- R7: Setup register field [8g+3:8g] selects channel 16g+field as the preset channel of group g (g = 0 or 1). Bit 16+g enables group g. The target for group g is at address 0x21+g. The preset condition is count ≥ target.
- R8: When an enabled group meets its condition, counting stops on every channel after a delay of STOP_LAT cycles (default 2). With a pulse on every cycle, the preset channel ends at target + STOP_LAT + 1.
- R9: Control read bits [9:8] are the hit flags of groups 0 and 1. Only the groups that meet the condition in the first detecting cycle set their flag, so both are set if they meet it together. No flag can newly set while the bank is stopped.
- R10: Hit flags stay set until a start or a control write with bit 3 set, and both of these clear them.
- R11: A group whose enable bit is low never ends the run and never sets its flag, even when its preset channel passes its target.
- R12: A target that is already at or below the preset channel's held count when a run starts ends that run at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pulse_in | input | 32 | Per-channel count pulses, one count per high cycle |
| inhibit_mask | input | 32 | Per-channel count block |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 6 | Register read address |
| rd_data | output | 32 | Combinational read data |

## Verification
Several properties are checked on every cycle:
- an inhibited channel never moves;
- no counter moves while the bank is stopped, except through a clear;
- a start leaves the bank running with clear flags;
- set flags hold;
- no flag appears while the bank is stopped.

Other behaviour can only be shown by the bench's scenarios, because it depends on programmed values and on how many pulses arrive:
- the exact overshoot past the target;
- which group wins when the groups race or tie;
- the greater-or-equal compare against a held count;
- a disabled group being ignored;
- reads taken during a run.

// File: rtl/presetctr_pkg.sv
package presetctr_pkg;
  // control register write bits (write-one commands)
  localparam int CTL_START = 0;
  localparam int CTL_STOP  = 1;
  localparam int CTL_CLR   = 2;
  localparam int CTL_HCLR  = 3;
  // control register read layout
  localparam int HIT_LSB   = 8;
  // setup register layout
  localparam int SEL_STRIDE = 8;
  localparam int EN_LSB     = 16;

  typedef struct packed {
    logic start;
    logic stop;
    logic clr;
    logic hclr;
  } ctl_cmd_t;
endpackage

// File: rtl/ctr_channel.sv
module ctr_channel #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          pulse,
  input  logic          inhibit,
  input  logic          clr,
  output logic [CW-1:0] count
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | (run & pulse & ~inhibit);
    cnt_d  = clr ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/preset_group.sv
module preset_group #(
  parameter int CW    = 32,
  parameter int GSIZE = 16,
  parameter int SEL_W = 4
) (
  input  logic [GSIZE*CW-1:0] grp_cnt,
  input  logic [SEL_W-1:0]    sel,
  input  logic [CW-1:0]       target,
  output logic                reached
);
  logic [CW-1:0] picked;

  always_comb begin
    picked = '0;
    for (int i = 0; i < GSIZE; i++)
      if (sel == SEL_W'(i)) picked = grp_cnt[i*CW +: CW];
    reached = (picked >= target);
  end
endmodule

// File: rtl/stop_ctrl.sv
module stop_ctrl #(
  parameter int N_GRP    = 2,
  parameter int STOP_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_GRP-1:0] reached,
  input  logic [N_GRP-1:0] grp_en,
  input  logic             start,
  input  logic             stop,
  input  logic             hclr,
  output logic             run_q,
  output logic [N_GRP-1:0] hit_q
);
  logic                run_d;
  logic [N_GRP-1:0]    hit_d, det;
  logic [STOP_LAT-1:0] pend_q, pend_d;
  logic [STOP_LAT:0]   shift;
  logic                fire;

  always_comb begin
    det   = reached & grp_en & {N_GRP{run_q & ~(|pend_q)}};
    fire  = |det;
    shift = {pend_q, fire};
    run_d  = run_q;
    hit_d  = hit_q | det;
    pend_d = shift[STOP_LAT-1:0];
    if (pend_q[STOP_LAT-1]) run_d = 1'b0;
    if (hclr) hit_d = '0;
    if (stop) begin
      run_d  = 1'b0;
      pend_d = '0;
    end
    if (start) begin
      run_d  = 1'b1;
      hit_d  = '0;
      pend_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      hit_q  <= '0;
      pend_q <= '0;
    end else begin
      run_q  <= run_d;
      hit_q  <= hit_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/presetctr_bank.sv
module presetctr_bank
  import presetctr_pkg::*;
#(
  parameter  int N_CH     = 32,
  parameter  int CW       = 32,
  parameter  int N_GRP    = 2,
  parameter  int STOP_LAT = 2,
  localparam int AW       = $clog2(N_CH + N_GRP + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] pulse_in,
  input  logic [N_CH-1:0] inhibit_mask,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [CW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [CW-1:0]   rd_data
);
  localparam int GSIZE      = N_CH / N_GRP;
  localparam int SEL_W      = $clog2(GSIZE);
  localparam int ADDR_CTL   = N_CH;
  localparam int ADDR_TGT   = N_CH + 1;
  localparam int ADDR_SETUP = N_CH + 1 + N_GRP;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  // command decode
  ctl_cmd_t cmd;
  logic     start_cmd, stop_cmd, clr_cmd, hclr_cmd;
  always_comb begin
    cmd.start = wr_en && (wr_addr == AW'(ADDR_CTL)) && wr_data[CTL_START];
    cmd.stop  = wr_en && (wr_addr == AW'(ADDR_CTL)) && wr_data[CTL_STOP];
    cmd.clr   = wr_en && (wr_addr == AW'(ADDR_CTL)) && wr_data[CTL_CLR];
    cmd.hclr  = wr_en && (wr_addr == AW'(ADDR_CTL)) && wr_data[CTL_HCLR];
  end
  assign start_cmd = cmd.start;
  assign stop_cmd  = cmd.stop;
  assign clr_cmd   = cmd.clr;
  assign hclr_cmd  = cmd.hclr;

  logic             run_q;
  logic [N_GRP-1:0] hit_q, reached, en_q;
  logic [N_CH*CW-1:0] cnt_flat;
  logic [CW-1:0]      cnt [N_CH];

  // channels
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    ctr_channel #(.CW(CW)) ch_i (
      .clk(clk), .rst_n(rst_n_s), .run(run_q), .pulse(pulse_in[c]),
      .inhibit(inhibit_mask[c]), .clr(clr_cmd), .count(cnt[c])
    );
    assign cnt_flat[c*CW +: CW] = cnt[c];
  end

  // per-group configuration and compare
  logic [CW-1:0]    tgt_q [N_GRP];
  logic [SEL_W-1:0] sel_q [N_GRP];
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic             tgt_we, setup_we;
    logic [CW-1:0]    tgt_d;
    logic [SEL_W-1:0] sel_d;
    logic             en_d;

    always_comb begin
      tgt_we   = wr_en && (wr_addr == AW'(ADDR_TGT + g));
      setup_we = wr_en && (wr_addr == AW'(ADDR_SETUP));
      tgt_d    = wr_data;
      sel_d    = wr_data[g*SEL_STRIDE +: SEL_W];
      en_d     = wr_data[EN_LSB + g];
    end

    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s) begin
        tgt_q[g] <= '0;
        sel_q[g] <= '0;
        en_q[g]  <= 1'b0;
      end else begin
        if (tgt_we) tgt_q[g] <= tgt_d;
        if (setup_we) begin
          sel_q[g] <= sel_d;
          en_q[g]  <= en_d;
        end
      end
    end

    preset_group #(.CW(CW), .GSIZE(GSIZE), .SEL_W(SEL_W)) pg_i (
      .grp_cnt(cnt_flat[g*GSIZE*CW +: GSIZE*CW]), .sel(sel_q[g]),
      .target(tgt_q[g]), .reached(reached[g])
    );
  end

  stop_ctrl #(.N_GRP(N_GRP), .STOP_LAT(STOP_LAT)) sc_i (
    .clk(clk), .rst_n(rst_n_s), .reached(reached), .grp_en(en_q),
    .start(start_cmd), .stop(stop_cmd), .hclr(hclr_cmd),
    .run_q(run_q), .hit_q(hit_q)
  );

  // read port
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_CH; i++)
      if (rd_addr == AW'(i)) rd_data = cnt[i];
    if (rd_addr == AW'(ADDR_CTL)) begin
      rd_data[0]                = run_q;
      rd_data[HIT_LSB +: N_GRP] = hit_q;
    end
    for (int g = 0; g < N_GRP; g++)
      if (rd_addr == AW'(ADDR_TGT + g)) rd_data = tgt_q[g];
    if (rd_addr == AW'(ADDR_SETUP))
      for (int g = 0; g < N_GRP; g++) begin
        rd_data[g*SEL_STRIDE +: SEL_W] = sel_q[g];
        rd_data[EN_LSB + g]            = en_q[g];
      end
  end
endmodule

// File: rtl/presetctr_chk.sv
module presetctr_chk #(
  parameter int N_CH  = 32,
  parameter int CW    = 32,
  parameter int N_GRP = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run_q,
  input logic [N_GRP-1:0]   hit_q,
  input logic [N_CH*CW-1:0] cnt_flat,
  input logic [N_CH-1:0]    inhibit_mask,
  input logic               start_cmd,
  input logic               stop_cmd,
  input logic               clr_cmd,
  input logic               hclr_cmd
);
  logic [N_CH*CW-1:0] inh_wide;
  for (genvar i = 0; i < N_CH; i++) begin : g_inh
    assign inh_wide[i*CW +: CW] = {CW{inhibit_mask[i]}};
  end

  p_inhibit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_cmd |=> (((cnt_flat ^ $past(cnt_flat)) & $past(inh_wide)) == '0));

  p_hold_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !clr_cmd && !start_cmd) |=> $stable(cnt_flat));

  p_hit_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((|hit_q) && !start_cmd && !hclr_cmd) |=> $stable(hit_q));

  p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cmd && !stop_cmd) |=> (run_q && hit_q == '0));

  p_no_hit_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start_cmd) |=> ((hit_q & ~$past(hit_q)) == '0));
endmodule

bind presetctr_bank presetctr_chk #(.N_CH(N_CH), .CW(CW), .N_GRP(N_GRP)) chk_i (
  .clk(clk), .rst_n(rst_n_s), .run_q(run_q), .hit_q(hit_q),
  .cnt_flat(cnt_flat), .inhibit_mask(inhibit_mask),
  .start_cmd(start_cmd), .stop_cmd(stop_cmd), .clr_cmd(clr_cmd),
  .hclr_cmd(hclr_cmd)
);

// File: tb/presetctr_bank_tb.sv
module presetctr_bank_tb_top;
  localparam int N_CH = 32, CW = 32, N_GRP = 2, STOP_LAT = 2, AW = 6;
  localparam int A_CTL = 32, A_T0 = 33, A_T1 = 34, A_SET = 35;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N_CH-1:0] pulse_in, inhibit_mask;
  logic            wr_en;
  logic [AW-1:0]   wr_addr, rd_addr;
  logic [CW-1:0]   wr_data, rd_data;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  presetctr_bank #(.N_CH(N_CH), .CW(CW), .N_GRP(N_GRP), .STOP_LAT(STOP_LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .inhibit_mask(inhibit_mask),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [CW-1:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulses(input logic [N_CH-1:0] m, input int n);
    pulse_in = m;
    repeat (n) @(negedge clk);
    pulse_in = '0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(0, v);     chk("R1 counter0", v, 0);
    rd(31, v);    chk("R1 counter31", v, 0);
    rd(A_CTL, v); chk("R1 ctrl", v, 0);
    rd(A_T1, v);  chk("R1 target1", v, 0);
    rd(A_SET, v); chk("R1 setup", v, 0);
  endtask

  task automatic t_count;
    logic [31:0] v;
    wr(A_CTL, 32'h5);
    pulses(32'h8, 10);
    wr(A_CTL, 32'h2);
    rd(3, v);     chk("R2 ch3 count", v, 10);
    rd(4, v);     chk("R2 ch4 idle", v, 0);
    rd(A_CTL, v); chk("R4 stopped", v, 0);
  endtask

  task automatic t_inhibit_hold;
    logic [31:0] v;
    inhibit_mask = 32'h20;
    wr(A_CTL, 32'h5);
    pulses(32'h60, 7);
    wr(A_CTL, 32'h2);
    inhibit_mask = '0;
    rd(5, v); chk("R3 inhibited ch5", v, 0);
    rd(6, v); chk("R2 ch6 count", v, 7);
    pulses(32'h60, 5);
    rd(6, v); chk("R4 hold while stopped", v, 7);
    wr(A_CTL, 32'h4);
    rd(6, v); chk("R5 clear", v, 0);
  endtask

  task automatic t_on_the_fly;
    logic [31:0] v1, v2;
    wr(A_CTL, 32'h5);
    pulse_in = 32'h80;
    repeat (3) @(negedge clk);
    rd(7, v1);
    repeat (5) @(negedge clk);
    rd(7, v2);
    chk("R6 read during run", v2 - v1, 5);
    repeat (2) @(negedge clk);
    pulse_in = '0;
    wr(A_CTL, 32'h2);
    rd(7, v1); chk("R6 no lost counts", v1, 10);
  endtask

  task automatic t_preset_g0;
    logic [31:0] v;
    wr(A_T0, 20);
    wr(A_T1, 1000);
    wr(A_SET, 32'h0001_0402);
    wr(A_CTL, 32'h5);
    pulses(32'h0010_0004, 40);
    rd(2, v);     chk("R8 g0 overshoot", v, 20 + STOP_LAT + 1);
    rd(20, v);    chk("R8 whole bank stopped", v, 20 + STOP_LAT + 1);
    rd(A_CTL, v); chk("R9 g0 hit", v, 32'h100);
    rd(A_SET, v); chk("R7 setup readback", v, 32'h0001_0402);
  endtask

  task automatic t_preset_g1_race;
    logic [31:0] v;
    wr(A_T0, 100);
    wr(A_T1, 10);
    wr(A_SET, 32'h0003_0402);
    wr(A_CTL, 32'h5);
    pulses(32'h0010_0004, 30);
    rd(20, v);    chk("R8 g1 overshoot", v, 10 + STOP_LAT + 1);
    rd(A_CTL, v); chk("R9 only g1 hit", v, 32'h200);
    repeat (3) @(negedge clk);
    rd(A_CTL, v); chk("R10 hit sticky", v, 32'h200);
    wr(A_CTL, 32'h8);
    rd(A_CTL, v); chk("R10 hit clear", v, 0);
  endtask

  task automatic t_tie;
    logic [31:0] v;
    wr(A_T0, 10);
    wr(A_T1, 10);
    wr(A_CTL, 32'h5);
    rd(A_CTL, v); chk("R10 start clears hits", v, 1);
    pulses(32'h0010_0004, 20);
    rd(A_CTL, v); chk("R9 tie sets both", v, 32'h300);
  endtask

  task automatic t_ge_at_start;
    logic [31:0] v;
    wr(A_T0, 5);
    wr(A_SET, 32'h0001_0402);
    wr(A_CTL, 32'h1);
    repeat (6) @(negedge clk);
    rd(A_CTL, v); chk("R12 immediate stop", v, 32'h100);
    rd(2, v);     chk("R12 count held", v, 13);
  endtask

  task automatic t_disabled;
    logic [31:0] v;
    wr(A_T0, 1000);
    wr(A_T1, 5);
    wr(A_SET, 32'h0001_0402);
    wr(A_CTL, 32'h5);
    pulses(32'h0010_0000, 30);
    rd(A_CTL, v); chk("R11 disabled group ignored", v, 1);
    rd(20, v);    chk("R11 counting continued", v, 30);
    wr(A_CTL, 32'h2);
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pulse_in = '0; inhibit_mask = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_count();
    t_inhibit_hold();
    t_on_the_fly();
    t_preset_g0();
    t_preset_g1_race();
    t_tie();
    t_ge_at_start();
    t_disabled();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule